// File: doc/BRIEF.md
# Fault-Tolerant Clock Synchronization Unit

This unit keeps a node's copy of the cluster-wide time in a time-triggered, slot-based network. Its time base is a phase accumulator. Every system clock (40 MHz in the intended system) the accumulator adds a rate increment, and each carry out of it is one macrotick. Because the increment need not divide the accumulator range evenly, the macrotick rate is a fractional division of the system clock. A count of macroticks forms the global time.

During a resynchronization round, other logic delivers the measured deviations of received frames, one per strobed cycle. The unit does not store the samples. It keeps the two largest and the two smallest values seen so far, plus a sample count. When the round-end strobe arrives, it forms a fault-tolerant midpoint: with four or more samples the extreme high and extreme low values are dropped, and the correction is the floor of the mean of the next-highest and next-lowest values, so a single arbitrarily wrong clock has no effect on the result. With two or three samples it falls back to the plain midpoint and raises a degraded flag. With fewer than two samples it applies no correction.

The correction, clamped to a symmetric limit, is added once to the global time. A right-shifted copy of it also trims the rate increment, so that repeated rounds steer the local rate towards the rest of the cluster.

Top module: `ftclk_sync`

## Requirements
- R1: While reset is high, and on the first cycle after it, `gtime` and `mtick` are 0, `corr` is 0 and `degraded` is 1.
- R2: Over any window of 2^INC_W consecutive clocks, exactly NOM_INC + trim macrotick pulses occur, where trim is the current rate trim (0 after reset). Each pulse lasts one cycle.
- R3: `gtime` rises by one on every cycle in which `mtick` is high. On the single apply cycle of a round, it also changes by the signed value of `corr`, modulo 2^TIME_W.
- R4: With four or more samples in a round, the correction is floor((second largest + second smallest) / 2). A single outlier, however large, therefore has no effect on it.
- R5: With two or three samples, the correction is floor((largest + smallest) / 2).
- R6: With zero or one sample, the correction is 0.
- R7: `degraded` is set when a round closes with fewer than four samples and cleared when a round closes with four or more. It keeps its value between round ends.
- R8: The correction is clamped to the range from -CORR_LIM to +CORR_LIM (1023 by default).
- R9: Only the first MAX_SAMP samples of a round are used; later samples are ignored. Every round end empties the sample store, so each round is evaluated on its own samples.
- R10: Count as edge 0 the clock edge that samples `round_end`. The new `corr` and `degraded` appear after edge 1. `gtime` takes the correction at edge 2. Before edge 1, `corr` keeps the previous round's value.
- R11: At the apply edge, trim becomes trim + (corr arithmetically shifted right by RATE_SH), clamped to ±TRIM_LIM. The rate increment is NOM_INC + trim.
- R12: A sample strobed in the same cycle as `round_end` belongs to the round that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Deviation sample strobe |
| smp_dev | input | SMP_W | Signed deviation of one received frame, in macroticks |
| round_end | input | 1 | One-cycle strobe that closes the resynchronization round |
| gtime | output | TIME_W | Global time in macroticks |
| mtick | output | 1 | One-cycle pulse per macrotick |
| corr | output | SMP_W | Signed correction of the last closed round |
| degraded | output | 1 | Last round closed with fewer than four samples |

## Verification
The bench builds the unit with an 8-bit accumulator, a nominal increment of 64, a trim limit of 32 and a trim shift of 4. One macrotick then takes about four clocks, and a 256-clock window holds exactly NOM_INC + trim pulses. This makes the rate trim, including its clamp, countable in a few hundred cycles. The sample width, the limit of eight samples and the correction limit of 1023 stay at their defaults, so the vector table can reach both saturation directions, the full store with an extra ninth sample, and every branch of the sample-count rule.

// File: rtl/ftclk_pkg.sv
package ftclk_pkg;

  // Fewest samples for which the outer pair is discarded.
  localparam int FULL_MIN = 4;

  typedef enum logic [1:0] {
    SYNC_NONE = 2'd0,  // zero or one sample: no correction
    SYNC_DEGR = 2'd1,  // two or three samples: plain midpoint
    SYNC_FULL = 2'd2   // enough samples: inner midpoint
  } sync_rule_e;

  function automatic sync_rule_e rule_for(input int n);
    if (n >= FULL_MIN) return SYNC_FULL;
    else if (n >= 2)   return SYNC_DEGR;
    else               return SYNC_NONE;
  endfunction

endpackage

// File: rtl/ftclk_top2.sv
// Keeps the two most extreme values (highest or lowest) of a stream.
module ftclk_top2 #(
  parameter int W    = 16,
  parameter bit HIGH = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                push,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] nxt_first,
  output logic signed [W-1:0] nxt_second
);

  localparam logic signed [W-1:0] INIT =
    HIGH ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

  logic signed [W-1:0] first_q, second_q;

  function automatic logic beats(input logic signed [W-1:0] a,
                                 input logic signed [W-1:0] b);
    return HIGH ? (a > b) : (a < b);
  endfunction

  always_comb begin
    nxt_first  = first_q;
    nxt_second = second_q;
    if (push) begin
      if (beats(x, first_q)) begin
        nxt_first  = x;
        nxt_second = first_q;
      end else if (beats(x, second_q)) begin
        nxt_second = x;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      first_q  <= INIT;
      second_q <= INIT;
    end else begin
      first_q  <= nxt_first;
      second_q <= nxt_second;
    end
  end

  // R4: the kept pair stays ranked
  a_r4_rank_order: assert property (@(posedge clk) disable iff (rst)
    HIGH ? (first_q >= second_q) : (first_q <= second_q));

endmodule

// File: rtl/ftclk_tracker.sv
// Collects one round of deviation samples and snapshots the ranked extremes.
module ftclk_tracker #(
  parameter int W        = 16,
  parameter int MAX_SAMP = 8,
  parameter int CNT_W    = $clog2(MAX_SAMP + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp_dev,
  input  logic                round_end,
  output logic                snap_valid,
  output logic signed [W-1:0] snap_hi1,
  output logic signed [W-1:0] snap_hi2,
  output logic signed [W-1:0] snap_lo1,
  output logic signed [W-1:0] snap_lo2,
  output logic [CNT_W-1:0]    snap_cnt
);

  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic                accept;
  logic signed [W-1:0] f_n [2];
  logic signed [W-1:0] s_n [2];

  // R9: samples past the store limit are dropped
  assign accept = smp_valid && (cnt_q < CNT_W'(MAX_SAMP));
  assign cnt_n  = accept ? cnt_q + CNT_W'(1) : cnt_q;

  // index 0 tracks the high side, index 1 the low side
  for (genvar g = 0; g < 2; g++) begin : g_side
    ftclk_top2 #(.W(W), .HIGH(g == 0)) u_side (
      .clk        (clk),
      .rst        (rst),
      .clr        (round_end),
      .push       (accept),
      .x          (smp_dev),
      .nxt_first  (f_n[g]),
      .nxt_second (s_n[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      snap_valid <= 1'b0;
      snap_hi1   <= '0;
      snap_hi2   <= '0;
      snap_lo1   <= '0;
      snap_lo2   <= '0;
      snap_cnt   <= '0;
    end else begin
      snap_valid <= round_end;
      if (round_end) begin
        // R12: a coincident sample is part of the closing round
        snap_hi1 <= f_n[0];
        snap_hi2 <= s_n[0];
        snap_lo1 <= f_n[1];
        snap_lo2 <= s_n[1];
        snap_cnt <= cnt_n;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_n;
      end
    end
  end

  // R9: the count never passes the store limit
  a_r9_count_cap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_SAMP));

  // R9: a round end empties the store
  a_r9_store_clear: assert property (@(posedge clk) disable iff (rst)
    round_end |=> (cnt_q == '0));

endmodule

// File: rtl/ftclk_midpoint.sv
// Turns a round snapshot into a clamped correction and a degraded flag.
module ftclk_midpoint
  import ftclk_pkg::*;
#(
  parameter int W        = 16,
  parameter int CNT_W    = 4,
  parameter int CORR_LIM = 1023
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                snap_valid,
  input  logic signed [W-1:0] snap_hi1,
  input  logic signed [W-1:0] snap_hi2,
  input  logic signed [W-1:0] snap_lo1,
  input  logic signed [W-1:0] snap_lo2,
  input  logic [CNT_W-1:0]    snap_cnt,
  output logic signed [W-1:0] corr_q,
  output logic                degraded_q,
  output logic                apply_q
);

  sync_rule_e          rule;
  logic signed [W-1:0] op_a, op_b;
  logic signed [W:0]   pair_sum, mid;
  logic signed [31:0]  mid32, clamped;

  always_comb begin
    rule = rule_for(int'(snap_cnt));
    unique case (rule)
      SYNC_FULL: begin op_a = snap_hi2; op_b = snap_lo2; end  // R4
      SYNC_DEGR: begin op_a = snap_hi1; op_b = snap_lo1; end  // R5
      default:   begin op_a = '0;       op_b = '0;       end  // R6
    endcase
    pair_sum = {op_a[W-1], op_a} + {op_b[W-1], op_b};
    mid      = pair_sum >>> 1;   // floor of the mean
    mid32    = 32'(mid);
    // R8: symmetric clamp
    if (mid32 > CORR_LIM)       clamped = CORR_LIM;
    else if (mid32 < -CORR_LIM) clamped = -CORR_LIM;
    else                        clamped = mid32;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_q     <= '0;
      degraded_q <= 1'b1;
      apply_q    <= 1'b0;
    end else begin
      apply_q <= snap_valid;
      if (snap_valid) begin
        corr_q     <= W'(clamped);
        degraded_q <= (rule != SYNC_FULL);  // R7
      end
    end
  end

  // R8: published correction stays within the limit
  a_r8_corr_clamp: assert property (@(posedge clk) disable iff (rst)
    (corr_q <= CORR_LIM) && (corr_q >= -CORR_LIM));

  // R6: sparse rounds produce no correction
  a_r6_sparse_zero: assert property (@(posedge clk) disable iff (rst)
    (snap_valid && snap_cnt <= CNT_W'(1)) |=> (corr_q == '0));

  // R7: flag reflects the sample count of the closed round
  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    snap_valid |=> (degraded_q == ($past(snap_cnt) < CNT_W'(FULL_MIN))));

  // R7: flag holds between round ends
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !snap_valid |=> $stable(degraded_q));

endmodule

// File: rtl/ftclk_rate.sv
// Fractional divider: phase accumulator with a correction-steered increment.
module ftclk_rate #(
  parameter int INC_W    = 16,
  parameter int NOM_INC  = 16384,
  parameter int TRIM_LIM = 2048,
  parameter int RATE_SH  = 4,
  parameter int CORR_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     apply,
  input  logic signed [CORR_W-1:0] corr,
  output logic                     carry
);

  localparam int TRIM_W = $clog2(TRIM_LIM + 1) + 1;

  logic [INC_W-1:0]         acc_q, acc_n, inc_c;
  logic signed [TRIM_W-1:0] trim_q;
  logic signed [31:0]       inc_full, step, trim_sum, trim_n;

  always_comb begin
    // R11: shifted correction accumulates into the trim, clamped
    step     = 32'(corr) >>> RATE_SH;
    trim_sum = 32'(trim_q) + step;
    if (trim_sum > TRIM_LIM)       trim_n = TRIM_LIM;
    else if (trim_sum < -TRIM_LIM) trim_n = -TRIM_LIM;
    else                           trim_n = trim_sum;
    inc_full = NOM_INC + 32'(trim_q);
    inc_c    = INC_W'(inc_full);
    // R2: one carry per accumulator wrap
    {carry, acc_n} = {1'b0, acc_q} + {1'b0, inc_c};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      trim_q <= '0;
    end else begin
      acc_q <= acc_n;
      if (apply) trim_q <= TRIM_W'(trim_n);
    end
  end

  // R11: the trim never leaves its range
  a_r11_trim_bound: assert property (@(posedge clk) disable iff (rst)
    (trim_q <= TRIM_LIM) && (trim_q >= -TRIM_LIM));

  // R11: the trim only moves on an apply cycle
  a_r11_trim_quiet: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(trim_q));

endmodule

// File: rtl/ftclk_sync.sv
module ftclk_sync #(
  parameter int SMP_W    = 16,
  parameter int MAX_SAMP = 8,
  parameter int TIME_W   = 32,
  parameter int INC_W    = 16,
  parameter int NOM_INC  = 16384,
  parameter int TRIM_LIM = 2048,
  parameter int RATE_SH  = 4,
  parameter int CORR_LIM = 1023
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_dev,
  input  logic                    round_end,
  output logic [TIME_W-1:0]       gtime,
  output logic                    mtick,
  output logic signed [SMP_W-1:0] corr,
  output logic                    degraded
);

  localparam int CNT_W = $clog2(MAX_SAMP + 1);

  logic                    snap_valid, apply, carry;
  logic signed [SMP_W-1:0] hi1, hi2, lo1, lo2;
  logic [CNT_W-1:0]        snap_cnt;
  logic [TIME_W-1:0]       time_q;
  logic                    tick_q;

  ftclk_tracker #(.W(SMP_W), .MAX_SAMP(MAX_SAMP), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .smp_dev    (smp_dev),
    .round_end  (round_end),
    .snap_valid (snap_valid),
    .snap_hi1   (hi1),
    .snap_hi2   (hi2),
    .snap_lo1   (lo1),
    .snap_lo2   (lo2),
    .snap_cnt   (snap_cnt)
  );

  ftclk_midpoint #(.W(SMP_W), .CNT_W(CNT_W), .CORR_LIM(CORR_LIM)) u_mid (
    .clk        (clk),
    .rst        (rst),
    .snap_valid (snap_valid),
    .snap_hi1   (hi1),
    .snap_hi2   (hi2),
    .snap_lo1   (lo1),
    .snap_lo2   (lo2),
    .snap_cnt   (snap_cnt),
    .corr_q     (corr),
    .degraded_q (degraded),
    .apply_q    (apply)
  );

  ftclk_rate #(
    .INC_W    (INC_W),
    .NOM_INC  (NOM_INC),
    .TRIM_LIM (TRIM_LIM),
    .RATE_SH  (RATE_SH),
    .CORR_W   (SMP_W)
  ) u_rate (
    .clk   (clk),
    .rst   (rst),
    .apply (apply),
    .corr  (corr),
    .carry (carry)
  );

  // R3: count macroticks, add the correction once per round
  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= carry;
      time_q <= time_q + TIME_W'(carry) + (apply ? TIME_W'(corr) : '0);
    end
  end

  assign gtime = time_q;
  assign mtick = tick_q;

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (gtime == '0 && !mtick && corr == '0 && degraded));

  // R3: outside the apply cycle time moves only with the macrotick
  a_r3_time_step: assert property (@(posedge clk) disable iff (rst)
    !apply |=> (gtime == $past(gtime) + TIME_W'(mtick)));

endmodule

// File: tb/ftclk_sync_test.sv
module ftclk_sync_test;

  localparam int CLK_PERIOD = 25;
  localparam int NV = 10;

  // vector table: samples packed 16 bits each, sample k at [16k +: 16]
  localparam logic [127:0] VSAMP [NV] = '{
    {16'sd0, 16'sd0, 16'sd0, 16'sd2, 16'sd300, 16'sd7, -16'sd4, 16'sd10},
    {16'sd0, 16'sd0, 16'sd0, 16'sd0, -16'sd30, -16'sd12, -16'sd8, -16'sd20},
    {16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd100, -16'sd6, 16'sd5},
    {16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd4, -16'sd7},
    {16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd500},
    128'd0,
    {-16'sd5000, 16'sd3100, 16'sd2900, 16'sd2800, 16'sd2700, 16'sd2600, 16'sd2500, 16'sd3000},
    {16'sd0, 16'sd0, 16'sd32767, -16'sd1800, -16'sd1900, -16'sd2200, -16'sd2100, -16'sd2000},
    {16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd9, 16'sd9, 16'sd9, 16'sd9},
    {16'sd8, 16'sd7, 16'sd6, 16'sd5, 16'sd4, 16'sd3, 16'sd2, 16'sd1}
  };
  localparam int VCNT  [NV] = '{5, 4, 3, 2, 1, 0, 8, 6, 4, 8};
  localparam int VCORR [NV] = '{6, -16, 47, -2, 0, 0, 1023, -1023, 9, 4};
  localparam bit VDEG  [NV] = '{0, 0, 1, 1, 1, 1, 0, 0, 0, 0};

  logic               clk = 1'b0;
  logic               rst;
  logic               smp_valid;
  logic signed [15:0] smp_dev;
  logic               round_end;
  logic [31:0]        gtime;
  logic               mtick;
  logic signed [15:0] corr;
  logic               degraded;

  int nchk = 0;
  int nerr = 0;
  int prev_corr = 0;
  bit prev_deg = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ftclk_sync #(
    .INC_W    (8),
    .NOM_INC  (64),
    .TRIM_LIM (32),
    .RATE_SH  (4)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_dev   (smp_dev),
    .round_end (round_end),
    .gtime     (gtime),
    .mtick     (mtick),
    .corr      (corr),
    .degraded  (degraded)
  );

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 8, 9: return "R4";
      2, 3:       return "R5";
      4, 5:       return "R6";
      default:    return "R8";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode 0: n samples; mode 1: one extra sample after them;
  // mode 2: one extra sample in the round_end cycle
  task automatic run_round(input int n, input logic [127:0] v, input int mode,
                           input int xs, input int exp_c, input bit exp_d,
                           input string req);
    logic [31:0] t0;
    int          tk;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_dev   = v[16*k +: 16];
    end
    if (mode == 1) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_dev   = 16'(xs);
    end
    @(negedge clk);
    smp_valid = (mode == 2);
    smp_dev   = 16'(xs);
    round_end = 1'b1;
    t0 = gtime;
    tk = 0;
    @(negedge clk);                    // after edge 0
    round_end = 1'b0;
    smp_valid = 1'b0;
    tk += int'(mtick);
    chk(int'(corr) == prev_corr, "R10", "corr before update", int'(corr), prev_corr);
    chk(degraded == prev_deg, "R7", "flag held", degraded, prev_deg);
    @(negedge clk);                    // after edge 1
    tk += int'(mtick);
    chk(int'(corr) == exp_c, req, "correction", int'(corr), exp_c);
    chk(degraded == exp_d, "R7", "degraded", degraded, exp_d);
    chk(gtime == t0 + 32'(tk), "R10", "time before apply", gtime, t0 + 32'(tk));
    @(negedge clk);                    // after edge 2
    tk += int'(mtick);
    chk(gtime == t0 + 32'(tk) + 32'(exp_c), "R3", "time after apply",
        gtime, t0 + 32'(tk) + 32'(exp_c));
    prev_corr = exp_c;
    prev_deg  = exp_d;
  endtask

  // R2: pulses in a 256-clock window, never two in a row
  task automatic count_window(input int exp_n, input string req);
    int n = 0;
    bit dbl = 1'b0;
    bit last = 1'b0;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      if (mtick && last) dbl = 1'b1;
      last = mtick;
      n += int'(mtick);
    end
    chk(n == exp_n, req, "macroticks per window", n, exp_n);
    chk(!dbl, "R2", "single-cycle pulse", dbl, 0);
  endtask

  initial begin
    rst       = 1'b1;
    smp_valid = 1'b0;
    smp_dev   = '0;
    round_end = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gtime == 0, "R1", "gtime", gtime, 0);
    chk(!mtick, "R1", "mtick", mtick, 0);
    chk(corr == 0, "R1", "corr", corr, 0);
    chk(degraded, "R1", "degraded", degraded, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(gtime <= 1 && corr == 0 && degraded, "R1", "first cycle", gtime, 0);

    // R2: untrimmed rate is NOM_INC pulses per 256 clocks
    count_window(64, "R2");
    // R11: +64 gives trim +4
    run_round(4, {64'd0, 16'sd64, 16'sd64, 16'sd64, 16'sd64}, 0, 0, 64, 1'b0, "R4");
    count_window(68, "R11");
    // R11: -1000 >>> 4 = -63, trim 4-63 clamps to -32
    run_round(4, {64'd0, -16'sd1000, -16'sd1000, -16'sd1000, -16'sd1000}, 0, 0,
              -1000, 1'b0, "R4");
    count_window(32, "R11");

    // vector table
    for (int i = 0; i < NV; i++)
      run_round(VCNT[i], VSAMP[i], 0, 0, VCORR[i], VDEG[i], tag_of(i));

    // R9: a ninth outlier sample is ignored (1..8 gives 4)
    run_round(8, VSAMP[9], 1, -30000, 4, 1'b0, "R9");
    // R12: three samples plus one coincident with round_end: {0,10,20,30} -> 15
    run_round(3, {80'd0, 16'sd30, 16'sd20, 16'sd10}, 2, 0, 15, 1'b0, "R12");
    // R9: the store is empty again: a single sample gives no correction
    run_round(1, {112'd0, 16'sd700}, 0, 0, 0, 1'b1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule